// File: doc/BRIEF.md
# Byte ALU with Registered Condition Flags

This block is the arithmetic and logic stage of a small accumulator machine. Each cycle it combines a working-register byte with a second byte, which is either a register-file value or an immediate literal, under a 4-bit operation code. The result leaves on a combinational output in the same cycle. When the update enable is high, the condition flags that the operation affects are captured on the next rising clock edge.

The block keeps the flags in its own status byte and reads the carry from it, so add-with-carry, subtract-with-borrow and the rotates chain across successive operations. Borrow is held inverted: a set carry after a subtraction means no borrow occurred. The block does not route the result to a destination and does not decode instruction words.

Top module: `alu8_core`

## Requirements
- R1: The status byte places negative at bit 4, signed overflow at bit 3, zero at bit 2, digit carry at bit 1 and carry at bit 0. Bits 7:5 always read 0, and an active-low reset clears the byte to 0x00.
- R2: Code 0 yields W+F. Code 1 yields W+F+C. Carry is set on a carry out of bit 7, and digit carry on a carry out of bit 3.
- R3: Code 2 yields F−W and code 3 yields literal−W, where the literal is driven on the F operand. Code 4 yields W−F−B and code 5 yields F−W−B, where B is the inverse of the stored carry. After any subtract, carry is 1 when bit 7 needed no borrow, and digit carry is 1 when bit 3 needed no borrow.
- R4: After codes 0 to 5, overflow equals the carry into bit 7 XOR the carry out of bit 7, which is the two's-complement overflow.
- R5: After every flag-updating operation, zero is 1 exactly when the result is 0x00, and negative equals result bit 7.
- R6: Codes 6, 7 and 8 yield W AND F, W OR F and W XOR F. They update only negative and zero, and overflow, digit carry and carry keep their values.
- R7: Code 9 rotates F left through carry and code 10 rotates it right through carry. The bit shifted out goes to carry. Digit carry takes F bit 3 on a left rotate and F bit 4 on a right rotate. Negative and zero are updated and overflow is kept.
- R8: Code 11 exchanges F bits 7:4 with bits 3:0 and leaves every flag unchanged.
- R9: When the update enable is low, the status byte holds its value. Codes 12 to 15 produce a result of 0x00 and leave the status byte unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_en_i | input | 1 | Captures the flags of this cycle's operation on the next rising edge |
| op_i | input | 4 | Operation code |
| w_i | input | 8 | Working-register operand |
| f_i | input | 8 | File-register or literal operand |
| result_o | output | 8 | Combinational operation result |
| status_o | output | 8 | Registered status byte |

## Verification
The assertions assume that op_i, w_i and f_i are stable and known around every rising edge at which op_en_i is high, because each check compares the flags with the operands and result of the previous cycle. The bench drives every input on the falling edge and holds it through the following rising edge. It brings the carry into a known state with a preceding add before each table entry, so the expected flags follow from that entry's operands alone. Reserved codes and cycles with the enable low are exercised the same way, so the hold assertions see defined values.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
   localparam int STATUS_W = 8;
   localparam int FLG_C    = 0;
   localparam int FLG_DC   = 1;
   localparam int FLG_Z    = 2;
   localparam int FLG_OV   = 3;
   localparam int FLG_N    = 4;
   localparam int FLAGS_W  = 5;

   typedef enum logic [3:0] {
      OP_ADD    = 4'd0,
      OP_ADDC   = 4'd1,
      OP_SUBFW  = 4'd2,
      OP_SUBLW  = 4'd3,
      OP_SUBWFB = 4'd4,
      OP_SUBFWB = 4'd5,
      OP_AND    = 4'd6,
      OP_OR     = 4'd7,
      OP_XOR    = 4'd8,
      OP_RLC    = 4'd9,
      OP_RRC    = 4'd10,
      OP_SWAP   = 4'd11,
      OP_RSV12  = 4'd12,
      OP_RSV13  = 4'd13,
      OP_RSV14  = 4'd14,
      OP_RSV15  = 4'd15
   } op_t;

   function automatic logic is_arith(op_t op);
      return op inside {OP_ADD, OP_ADDC, OP_SUBFW, OP_SUBLW, OP_SUBWFB, OP_SUBFWB};
   endfunction

   function automatic logic is_logic(op_t op);
      return op inside {OP_AND, OP_OR, OP_XOR};
   endfunction

   function automatic logic is_rot(op_t op);
      return op inside {OP_RLC, OP_RRC};
   endfunction
endpackage

// File: rtl/alu8_adder.sv
module alu8_adder #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             cin_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             cout_o,
   output logic             hcout_o,
   output logic             ovf_o
);
   localparam int HALF  = WIDTH / 2;
   localparam int MID_W = WIDTH - HALF - 1;

   // Segmented chain: low half, middle bits, top bit, so the carries
   // out of bit HALF-1 and into the top bit appear as segment outputs.
   logic [HALF:0]  lo_seg;
   logic [MID_W:0] mid_seg;
   logic [1:0]     top_seg;

   always_comb begin
      lo_seg  = {1'b0, a_i[HALF-1:0]} + {1'b0, b_i[HALF-1:0]}
              + {{HALF{1'b0}}, cin_i};
      mid_seg = {1'b0, a_i[WIDTH-2:HALF]} + {1'b0, b_i[WIDTH-2:HALF]}
              + {{MID_W{1'b0}}, lo_seg[HALF]};
      top_seg = {1'b0, a_i[WIDTH-1]} + {1'b0, b_i[WIDTH-1]}
              + {1'b0, mid_seg[MID_W]};
   end

   assign sum_o   = {top_seg[0], mid_seg[MID_W-1:0], lo_seg[HALF-1:0]};
   assign cout_o  = top_seg[1];
   assign hcout_o = lo_seg[HALF];
   assign ovf_o   = top_seg[1] ^ mid_seg[MID_W];
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
   import alu8_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  op_t              op_i,
   input  logic [WIDTH-1:0] w_i,
   input  logic [WIDTH-1:0] f_i,
   input  logic             cin_i,
   output logic [WIDTH-1:0] res_o,
   output logic             rot_c_o,
   output logic             rot_dc_o
);
   localparam int HALF = WIDTH / 2;

   logic [WIDTH-1:0] rl_v, rr_v, sw_v;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if (i == 0) begin : g_lsb
         assign rl_v[i] = cin_i;
      end else begin : g_lsh
         assign rl_v[i] = f_i[i-1];
      end
      if (i == WIDTH-1) begin : g_msb
         assign rr_v[i] = cin_i;
      end else begin : g_rsh
         assign rr_v[i] = f_i[i+1];
      end
      assign sw_v[i] = f_i[(i + HALF) % WIDTH];
   end

   always_comb begin
      unique case (op_i)
         OP_AND:  res_o = w_i & f_i;
         OP_OR:   res_o = w_i | f_i;
         OP_XOR:  res_o = w_i ^ f_i;
         OP_RLC:  res_o = rl_v;
         OP_RRC:  res_o = rr_v;
         OP_SWAP: res_o = sw_v;
         default: res_o = '0;
      endcase
   end

   assign rot_c_o  = (op_i == OP_RLC) ? f_i[WIDTH-1] : f_i[0];
   assign rot_dc_o = (op_i == OP_RLC) ? f_i[HALF-1]  : f_i[HALF];
endmodule

// File: rtl/alu8_status.sv
module alu8_status
   import alu8_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                en_i,
   input  op_t                 op_i,
   input  logic [WIDTH-1:0]    res_i,
   input  logic                cout_i,
   input  logic                hcout_i,
   input  logic                ovf_i,
   input  logic                rot_c_i,
   input  logic                rot_dc_i,
   output logic [STATUS_W-1:0] status_o
);
   logic [FLAGS_W-1:0] flags_q, flags_d;
   logic               res_zero;

   assign res_zero = (res_i == '0);

   always_comb begin
      flags_d = flags_q;
      if (en_i) begin
         if (is_arith(op_i)) begin
            flags_d[FLG_N]  = res_i[WIDTH-1];
            flags_d[FLG_OV] = ovf_i;
            flags_d[FLG_Z]  = res_zero;
            flags_d[FLG_DC] = hcout_i;
            flags_d[FLG_C]  = cout_i;
         end else if (is_logic(op_i)) begin
            flags_d[FLG_N]  = res_i[WIDTH-1];
            flags_d[FLG_Z]  = res_zero;
         end else if (is_rot(op_i)) begin
            flags_d[FLG_N]  = res_i[WIDTH-1];
            flags_d[FLG_Z]  = res_zero;
            flags_d[FLG_DC] = rot_dc_i;
            flags_d[FLG_C]  = rot_c_i;
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flags_q <= '0;
      else         flags_q <= flags_d;
   end

   assign status_o = {{(STATUS_W-FLAGS_W){1'b0}}, flags_q};

   // R9: status frozen when disabled or on a reserved code
   assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_i || op_i inside {OP_RSV12, OP_RSV13, OP_RSV14, OP_RSV15})
      |=> $stable(flags_q));

   assert_swap_keeps_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && op_i == OP_SWAP) |=> $stable(flags_q));

   assert_logic_keeps_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && is_logic(op_i)) |=>
      (flags_q[FLG_OV] == $past(flags_q[FLG_OV]) &&
       flags_q[FLG_DC] == $past(flags_q[FLG_DC]) &&
       flags_q[FLG_C]  == $past(flags_q[FLG_C])));

   assert_zero_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && (is_arith(op_i) || is_logic(op_i) || is_rot(op_i)))
      |=> (flags_q[FLG_Z] == ($past(res_i) == '0)));

   assert_neg_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && (is_arith(op_i) || is_logic(op_i) || is_rot(op_i)))
      |=> (flags_q[FLG_N] == $past(res_i[WIDTH-1])));
endmodule

// File: rtl/alu8_core.sv
module alu8_core
   import alu8_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                op_en_i,
   input  logic [3:0]          op_i,
   input  logic [DATA_W-1:0]   w_i,
   input  logic [DATA_W-1:0]   f_i,
   output logic [DATA_W-1:0]   result_o,
   output logic [STATUS_W-1:0] status_o
);
   localparam int HALF = DATA_W / 2;

   if ((DATA_W % 2) != 0 || DATA_W < 4) begin : g_bad_width
      $error("alu8_core: DATA_W must be even and at least 4");
   end
   if (HALF * 2 != DATA_W) begin : g_bad_half
      $error("alu8_core: half width does not divide DATA_W");
   end

   op_t              op;
   logic             carry_q;
   logic [DATA_W-1:0] add_a, add_b, add_sum, bit_res;
   logic             add_cin, add_cout, add_hc, add_ovf, rot_c, rot_dc;

   assign op      = op_t'(op_i);
   assign carry_q = status_o[FLG_C];

   // Every arithmetic code maps onto one adder: subtraction inverts the
   // subtrahend and feeds 1 (or the stored no-borrow carry) as carry-in.
   always_comb begin
      add_a   = w_i;
      add_b   = f_i;
      add_cin = 1'b0;
      unique case (op)
         OP_ADDC:            add_cin = carry_q;
         OP_SUBFW, OP_SUBLW: begin add_a = f_i; add_b = ~w_i; add_cin = 1'b1;    end
         OP_SUBWFB:          begin add_a = w_i; add_b = ~f_i; add_cin = carry_q; end
         OP_SUBFWB:          begin add_a = f_i; add_b = ~w_i; add_cin = carry_q; end
         default: ;
      endcase
   end

   alu8_adder #(.WIDTH(DATA_W)) u_adder (
      .a_i(add_a), .b_i(add_b), .cin_i(add_cin),
      .sum_o(add_sum), .cout_o(add_cout), .hcout_o(add_hc), .ovf_o(add_ovf)
   );

   alu8_bitops #(.WIDTH(DATA_W)) u_bitops (
      .op_i(op), .w_i(w_i), .f_i(f_i), .cin_i(carry_q),
      .res_o(bit_res), .rot_c_o(rot_c), .rot_dc_o(rot_dc)
   );

   assign result_o = is_arith(op) ? add_sum : bit_res;

   alu8_status #(.WIDTH(DATA_W)) u_status (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(op_en_i), .op_i(op),
      .res_i(result_o), .cout_i(add_cout), .hcout_i(add_hc), .ovf_i(add_ovf),
      .rot_c_i(rot_c), .rot_dc_i(rot_dc), .status_o(status_o)
   );

   assert_add_carry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_en_i && op == OP_ADD) |=>
      (status_o[FLG_C] == ($past(w_i) > ~$past(f_i))));

   assert_sub_noborrow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_en_i && op == OP_SUBFW) |=>
      (status_o[FLG_C] == ($past(f_i) >= $past(w_i))));

   assert_rotl_carry_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_en_i && op == OP_RLC) |=> (status_o[FLG_C] == $past(f_i[DATA_W-1])));

   assert_rotr_carry_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_en_i && op == OP_RRC) |=> (status_o[FLG_C] == $past(f_i[0])));

   assert_upper_clear_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      status_o[STATUS_W-1:FLAGS_W] == '0);
endmodule

// File: tb/alu8_core_bench.sv
module alu8_core_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       op_en = 1'b0;
   logic [3:0] op = 4'd0;
   logic [7:0] w = 8'h00;
   logic [7:0] f = 8'h00;
   logic [7:0] result;
   logic [7:0] status;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   alu8_core u_alu8_core (
      .clk_i(clk), .rst_ni(rst_n), .op_en_i(op_en), .op_i(op),
      .w_i(w), .f_i(f), .result_o(result), .status_o(status)
   );

   // {op, w, f, carry preset, expected result, expected status}
   localparam logic [36:0] VECS [NVEC] = '{
      {4'd0,  8'h3C, 8'h44, 1'b0, 8'h80, 8'h1A},
      {4'd0,  8'hF0, 8'h10, 1'b1, 8'h00, 8'h05},
      {4'd1,  8'h0F, 8'h00, 1'b1, 8'h10, 8'h02},
      {4'd2,  8'h01, 8'h00, 1'b0, 8'hFF, 8'h10},
      {4'd3,  8'h05, 8'h05, 1'b0, 8'h00, 8'h07},
      {4'd4,  8'h80, 8'h01, 1'b1, 8'h7F, 8'h09},
      {4'd4,  8'h10, 8'h00, 1'b0, 8'h0F, 8'h01},
      {4'd5,  8'h01, 8'h80, 1'b0, 8'h7E, 8'h09},
      {4'd6,  8'hF0, 8'h0F, 1'b1, 8'h00, 8'h07},
      {4'd7,  8'h80, 8'h01, 1'b0, 8'h81, 8'h10},
      {4'd8,  8'h5A, 8'hFF, 1'b1, 8'hA5, 8'h13},
      {4'd9,  8'h00, 8'h88, 1'b1, 8'h11, 8'h03},
      {4'd10, 8'h00, 8'h01, 1'b0, 8'h00, 8'h05},
      {4'd10, 8'h00, 8'h10, 1'b1, 8'h88, 8'h12},
      {4'd11, 8'h00, 8'hA5, 1'b1, 8'h5A, 8'h07},
      {4'd15, 8'h12, 8'h34, 1'b0, 8'h00, 8'h04}
   };

   function automatic string tag_of(logic [3:0] code);
      if (code <= 4'd1)  return "R2/R4/R5";
      if (code <= 4'd5)  return "R3/R4/R5";
      if (code <= 4'd8)  return "R6/R5";
      if (code <= 4'd10) return "R7/R5";
      if (code == 4'd11) return "R8";
      return "R9";
   endfunction

   task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got 0x%02h expected 0x%02h", tag, what, act, exp);
      end
   endtask

   // One enabled cycle; no checks. Used to put the carry in a known state.
   task automatic step(logic [3:0] c, logic [7:0] a, logic [7:0] b);
      @(negedge clk);
      op = c; w = a; f = b; op_en = 1'b1;
      @(negedge clk);
      op_en = 1'b0;
   endtask

   task automatic preset_carry(logic cset);
      if (cset) step(4'd0, 8'hFF, 8'h01);   // status 0x07
      else      step(4'd0, 8'h00, 8'h00);   // status 0x04
   endtask

   task automatic run_check(string tag, logic [3:0] c, logic [7:0] a, logic [7:0] b,
                            logic en, logic [7:0] exp_res, logic [7:0] exp_st);
      @(negedge clk);
      op = c; w = a; f = b; op_en = en;
      #1;
      check(tag, "result", result, exp_res);
      @(negedge clk);
      op_en = 1'b0;
      check(tag, "status", status, exp_st);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: got hung run expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (2) @(negedge clk);
      check("R1", "reset status", status, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "status after release", status, 8'h00);

      for (int i = 0; i < NVEC; i++) begin
         preset_carry(VECS[i][16]);
         run_check(tag_of(VECS[i][36:33]), VECS[i][36:33], VECS[i][32:25],
                   VECS[i][24:17], 1'b1, VECS[i][15:8], VECS[i][7:0]);
      end

      // R2: add-with-carry wraps to zero with both carries
      preset_carry(1'b1);
      run_check("R2", 4'd1, 8'hFF, 8'h00, 1'b1, 8'h00, 8'h07);

      // R6: logic op keeps a set overflow flag
      step(4'd0, 8'h40, 8'h40);              // status 0x18
      run_check("R6", 4'd6, 8'h01, 8'hFF, 1'b1, 8'h01, 8'h08);

      // R9: enable low leaves flags alone though the op would change them
      preset_carry(1'b1);
      run_check("R9", 4'd0, 8'h01, 8'h01, 1'b0, 8'h02, 8'h07);

      // R9: reserved code with a set carry
      run_check("R9", 4'd12, 8'hFF, 8'hFF, 1'b1, 8'h00, 8'h07);

      // R1: reset clears a populated status byte
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R1", "async reset", status, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule